// File: doc/BRIEF.md
# Console Terminal Register Block

This block puts a character console at a fixed page of a processor's word-wide address space. Software polls it or takes interrupts from it with ordinary loads and stores. The receive side captures one byte at a time from a keyboard source that strobes a valid line. The transmit side hands one byte at a time to a display sink over a ready/valid handshake.

Each direction has two registers: a control word and a data word. The control word carries a status flag and a software-set interrupt enable. The receive control word also carries a sticky overrun flag. Loads return their data one cycle after the request. Loading the receive data word consumes the waiting character. Each direction drives its own level-sensitive interrupt line.

Top module: `console_mmio`

## Requirements
- R1: The page base is 0xFFFF0000. The receive control word is at offset 0x0, receive data at 0x4, transmit control at 0x8 and transmit data at 0xC. An access is accepted only when address bits 31:4 match the base and bits 1:0 are zero. Any other access changes no state, and a load from such an address returns 0.
- R2: A load (bus_rd=1 for one cycle) presents its word on bus_rdata on the cycle after the request. In the control words, bit 0 is the status flag, bit 1 is the interrupt enable and bit 2 is the receive overrun flag. Every other bit reads 0, and the transmit data word reads 0.
- R3: A cycle with kb_valid=1 stores kb_char and sets the receive status flag. The receive data word shows the character in bits 7:0, with bits 31:8 at zero.
- R4: A load of the receive data word clears the receive status flag on the next cycle. If a new character arrives in the same cycle, the flag stays at 1 and the new character is kept.
- R5: A character that arrives while the receive status flag is 1 replaces the held one. The flag stays at 1 and the overrun flag is set. A load of the receive control word clears the overrun flag after returning it.
- R6: A store to the transmit data word while the transmit status flag is 1 drives bits 7:0 onto disp_char with disp_valid=1 from the next cycle. The transmit status flag reads 0 while disp_valid is 1. disp_valid and disp_char hold until a cycle in which disp_ready is 1, after which disp_valid is 0 and the flag reads 1.
- R7: A store to the transmit data word while the transmit status flag is 0 is dropped, and disp_char keeps the character being sent.
- R8: A store to a control word writes only the interrupt enable, from bit 1 of the store data. Status and overrun flags are unaffected.
- R9: irq_rx is 1 exactly when the receive status flag and receive enable are both 1. irq_tx is 1 exactly when the transmit status flag and transmit enable are both 1.
- R10: While rst is high and after it, both enables, the receive status flag, the overrun flag, disp_valid and bus_rdata are 0, and the transmit status flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the load or store |
| bus_rd | input | 1 | Load request, one cycle per access |
| bus_wr | input | 1 | Store request, one cycle per access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid the cycle after bus_rd |
| kb_valid | input | 1 | Keyboard character strobe |
| kb_char | input | 8 | Keyboard character |
| disp_valid | output | 1 | Display character pending |
| disp_char | output | 8 | Display character |
| disp_ready | input | 1 | Display accepts the pending character |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The assertions check the following on every cycle:
- arrival sets the receive flag;
- consuming the data word clears the flag;
- a clobbered character raises overrun;
- the enables move only on control stores;
- the display output holds through backpressure;
- a stalled store leaves disp_char untouched;
- off-page or misaligned loads return zero.

Only the bench's scenarios can show the following:
- the exact packing of the control words;
- the overrun flag clearing after it has been returned;
- a consume that coincides with an arrival;
- the interrupt lines following status and enable in both directions;
- the state after a reset in the middle of a run.

// File: rtl/con_pkg.sv
package con_pkg;
  localparam int NUM_REGS = 4;
  localparam int BIT_RDY  = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_OVR  = 2;

  typedef enum logic [1:0] {
    REG_RX_CTRL = 2'd0,
    REG_RX_DATA = 2'd1,
    REG_TX_CTRL = 2'd2,
    REG_TX_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/con_decode.sv
module con_decode
  import con_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter int              OFS_W  = 4,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd,
  input  logic                wr,
  output logic                hit,
  output logic [NUM_REGS-1:0] rd_sel,
  output logic [NUM_REGS-1:0] wr_sel
);
  localparam int IDX_W = OFS_W - 2;

  logic [IDX_W-1:0] idx;

  assign idx = addr[OFS_W-1:2];
  assign hit = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]) && (addr[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign rd_sel[g] = rd && hit && (idx == IDX_W'(g));
    assign wr_sel[g] = wr && hit && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/con_rx_side.sv
module con_rx_side #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_char,
  input  logic              rd_data,
  input  logic              rd_ctrl,
  input  logic              wr_ctrl,
  input  logic              wr_ie,
  output logic              rdy,
  output logic              ie,
  output logic              ovr,
  output logic [CHAR_W-1:0] char_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy    <= 1'b0;
      ie     <= 1'b0;
      ovr    <= 1'b0;
      char_q <= '0;
    end else begin
      if (wr_ctrl) ie <= wr_ie;
      if (kb_valid) begin
        char_q <= kb_char;
        rdy    <= 1'b1;
      end else if (rd_data) begin
        rdy <= 1'b0;
      end
      if (kb_valid && rdy && !rd_data) ovr <= 1'b1;
      else if (rd_ctrl)                ovr <= 1'b0;
    end
  end

  assign irq = rdy && ie;

  p_rx_set_r3: assert property (@(posedge clk) disable iff (rst)
    kb_valid |=> (rdy && char_q == $past(kb_char)));
  p_rx_consume_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !kb_valid) |=> !rdy);
  p_rx_overrun_r5: assert property (@(posedge clk) disable iff (rst)
    (kb_valid && rdy && !rd_data) |=> (ovr && rdy));
  p_rx_ie_only_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ie));
endmodule

// File: rtl/con_tx_side.sv
module con_tx_side #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic              wr_ctrl,
  input  logic              wr_ie,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  output logic              rdy,
  output logic              ie,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_char  <= '0;
      ie         <= 1'b0;
    end else begin
      if (wr_ctrl) ie <= wr_ie;
      if (disp_valid) begin
        if (disp_ready) disp_valid <= 1'b0;
      end else if (wr_data) begin
        disp_valid <= 1'b1;
        disp_char  <= wr_char;
      end
    end
  end

  assign rdy = !disp_valid;
  assign irq = rdy && ie;

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_char)));
  p_tx_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_data && disp_valid) |=> $stable(disp_char));
  p_tx_ie_only_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ie));
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import con_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter int                DATA_W = 32,
  parameter int                CHAR_W = 8,
  parameter int                OFS_W  = 4,
  parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_char,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_ready,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic                hit;
  logic [NUM_REGS-1:0] rd_sel, wr_sel;
  logic                rx_rdy, rx_ie, rx_ovr, tx_rdy, tx_ie;
  logic [CHAR_W-1:0]   rx_char;
  logic [DATA_W-1:0]   reg_word [NUM_REGS];
  logic [DATA_W-1:0]   rd_word;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];

  con_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BASE(BASE)) i_decode (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .hit(hit), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  con_rx_side #(.CHAR_W(CHAR_W)) i_rx (
    .clk(clk), .rst(rst), .kb_valid(kb_valid), .kb_char(kb_char),
    .rd_data(rd_sel[REG_RX_DATA]), .rd_ctrl(rd_sel[REG_RX_CTRL]),
    .wr_ctrl(wr_sel[REG_RX_CTRL]), .wr_ie(bus_wdata[BIT_IE]),
    .rdy(rx_rdy), .ie(rx_ie), .ovr(rx_ovr), .char_q(rx_char), .irq(irq_rx)
  );

  con_tx_side #(.CHAR_W(CHAR_W)) i_tx (
    .clk(clk), .rst(rst), .wr_data(wr_sel[REG_TX_DATA]),
    .wr_ctrl(wr_sel[REG_TX_CTRL]), .wr_ie(bus_wdata[BIT_IE]),
    .wr_char(bus_wdata[CHAR_W-1:0]), .disp_ready(disp_ready),
    .disp_valid(disp_valid), .disp_char(disp_char),
    .rdy(tx_rdy), .ie(tx_ie), .irq(irq_tx)
  );

  always_comb begin
    reg_word[REG_RX_CTRL]          = '0;
    reg_word[REG_RX_CTRL][BIT_RDY] = rx_rdy;
    reg_word[REG_RX_CTRL][BIT_IE]  = rx_ie;
    reg_word[REG_RX_CTRL][BIT_OVR] = rx_ovr;
    reg_word[REG_RX_DATA]          = {{(DATA_W-CHAR_W){1'b0}}, rx_char};
    reg_word[REG_TX_CTRL]          = '0;
    reg_word[REG_TX_CTRL][BIT_RDY] = tx_rdy;
    reg_word[REG_TX_CTRL][BIT_IE]  = tx_ie;
    reg_word[REG_TX_DATA]          = '0;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel[i]) rd_word = rd_word | reg_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  p_offpage_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> (bus_rdata == '0));
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[3:2] == 2'd2) |=> (bus_rdata[DATA_W-1:2] == '0));
endmodule

// File: tb/test_console_mmio.sv
module test_console_mmio;
  localparam int PERIOD = 10;
  localparam logic [31:0] RXC = 32'hFFFF_0000, RXD = 32'hFFFF_0004,
                          TXC = 32'hFFFF_0008, TXD = 32'hFFFF_000C;

  typedef struct packed {
    logic [1:0]  op;    // 0 idle, 1 load, 2 store
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        kbv;
    logic [7:0]  kbc;
    logic        drdy;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'd1, RXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h0, 4'd10},           // R10 rx ctrl clear
    '{2'd1, TXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h1, 4'd10},           // R10 tx ready
    '{2'd0, RXC, 32'h0, 1'b1, 8'h41, 1'b0, 1'b0, 32'h0, 4'd3},
    '{2'd1, RXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h1, 4'd3},            // R3 ready set
    '{2'd1, RXD, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h41, 4'd3},           // R3 char
    '{2'd1, RXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h0, 4'd4},            // R4 consumed
    '{2'd2, RXC, 32'hFFFF_FFFF, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 4'd8},
    '{2'd1, RXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h2, 4'd8},            // R8 only ie
    '{2'd0, RXC, 32'h0, 1'b1, 8'h11, 1'b0, 1'b0, 32'h0, 4'd5},
    '{2'd0, RXC, 32'h0, 1'b1, 8'h22, 1'b0, 1'b0, 32'h0, 4'd5},
    '{2'd1, RXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h7, 4'd5},            // R5 overrun seen
    '{2'd1, RXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h3, 4'd5},            // R5 overrun cleared
    '{2'd1, RXD, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h22, 4'd5},           // R5 newest kept
    '{2'd2, TXD, 32'h1234_5658, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 4'd6},
    '{2'd1, TXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h0, 4'd6},            // R6 busy
    '{2'd2, TXD, 32'h0000_0099, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 4'd7},
    '{2'd0, RXC, 32'h0, 1'b0, 8'h00, 1'b1, 1'b0, 32'h0, 4'd6},
    '{2'd1, TXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h1, 4'd6},            // R6 ready again
    '{2'd1, 32'hFFFE_0000, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h0, 4'd1},  // R1 off page
    '{2'd2, 32'hFFFF_000A, 32'h2, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 4'd1},
    '{2'd1, TXC, 32'h0, 1'b0, 8'h00, 1'b0, 1'b1, 32'h1, 4'd1}             // R1 misaligned ignored
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic        kb_valid = 1'b0, disp_ready = 1'b0;
  logic [7:0]  kb_char = '0, disp_char;
  logic        disp_valid, irq_rx, irq_tx;
  int          n_chk = 0, n_bad = 0;
  logic        seen_char_58 = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  console_mmio i_console_mmio (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kb_valid(kb_valid), .kb_char(kb_char),
    .disp_valid(disp_valid), .disp_char(disp_char), .disp_ready(disp_ready),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                      input logic kv, input logic [7:0] kc, input logic dr);
    @(negedge clk);
    bus_rd = (op == 2'd1); bus_wr = (op == 2'd2); bus_addr = a; bus_wdata = d;
    kb_valid = kv; kb_char = kc; disp_ready = dr;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; kb_valid = 1'b0; disp_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    check("R10", {31'b0, disp_valid}, 32'h0);
    check("R10", bus_rdata, 32'h0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].kbv, VECS[i].kbc, VECS[i].drdy);
      if (i == 13) seen_char_58 = (disp_char == 8'h58) && disp_valid;
      if (i == 15) check("R7", {24'b0, disp_char}, 32'h58);
      if (VECS[i].chk) check($sformatf("R%0d", VECS[i].req), bus_rdata, VECS[i].exp);
    end
    check("R6", {31'b0, seen_char_58}, 32'h1);

    // R4 corner: consume and arrival in the same cycle
    step(2'd0, RXC, 0, 1'b1, 8'h10, 1'b0);
    check("R9", {31'b0, irq_rx}, 32'h1);
    step(2'd1, RXD, 0, 1'b1, 8'h20, 1'b0);
    check("R4", bus_rdata, 32'h10);
    step(2'd1, RXC, 0, 1'b0, 8'h00, 1'b0);
    check("R4", bus_rdata, 32'h3);
    step(2'd1, RXD, 0, 1'b0, 8'h00, 1'b0);
    check("R4", bus_rdata, 32'h20);
    check("R9", {31'b0, irq_rx}, 32'h0);

    // R9 / R6 transmit interrupt and backpressure
    check("R9", {31'b0, irq_tx}, 32'h0);
    step(2'd2, TXC, 32'h2, 1'b0, 8'h00, 1'b0);
    check("R9", {31'b0, irq_tx}, 32'h1);
    step(2'd2, TXD, 32'hABCD_EF5A, 1'b0, 8'h00, 1'b0);
    check("R6", {23'b0, disp_valid, disp_char}, 32'h15A);
    check("R9", {31'b0, irq_tx}, 32'h0);
    repeat (3) @(negedge clk);
    check("R6", {23'b0, disp_valid, disp_char}, 32'h15A);
    step(2'd0, RXC, 0, 1'b0, 8'h00, 1'b1);
    check("R6", {31'b0, disp_valid}, 32'h0);
    check("R9", {31'b0, irq_tx}, 32'h1);

    // R10 reset in the middle of a run
    step(2'd0, RXC, 0, 1'b1, 8'h33, 1'b0);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R10", {30'b0, irq_rx, irq_tx}, 32'h0);
    step(2'd1, RXC, 0, 1'b0, 8'h00, 1'b0);
    check("R10", bus_rdata, 32'h0);
    step(2'd1, TXC, 0, 1'b0, 8'h00, 1'b0);
    check("R10", bus_rdata, 32'h1);
    step(2'd1, TXD, 0, 1'b0, 8'h00, 1'b0);
    check("R2", bus_rdata, 32'h0);

    finish_run();
  end
endmodule